// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of an 8-bit microcoded processor datapath. It holds two operand registers, T1 and T2, loaded through explicit load strobes from a shared data input. It also keeps a processor status byte and a small amount of private carry state. Each cycle the sequencer presents an operation code, a flag-write mode and two carry-source controls. The block registers an 8-bit result and updates only the status bits that the mode allows.

Single-operand operations act on T1. Two-operand operations treat T2 as the accumulator side, so subtraction forms T2 minus T1. A private link carry lets 16-bit pointers be incremented or decremented one byte at a time without disturbing the visible carry flag. Decimal adjust is a two-issue operation: the first issue computes the correction and the second applies it.

Top module: `alu8_flags`

## Requirements
- R1: While reset is low, and until the internal synchronised reset releases, T1, T2 and result are 0x00 and flags reads 0x02.
- R2: On a clock edge, ld_t1 loads T1 from din and ld_t2 loads T2 from din. clr_t1 zeroes T1 at that edge and overrides ld_t1. The operation issued in a cycle uses the T1/T2 values held before that edge.
- R3: op 1 (add) gives T2+T1, op 2 (add with carry) gives T2+T1+c, op 3 (subtract) gives T2-T1, and op 4 (subtract with borrow) gives T2-T1-c. Here c is the selected carry. The carry candidate is the carry out, or the borrow for ops 3 and 4. The aux-carry candidate is the carry into bit 4 of T2 + T1, or of T2 + ~T1 + (1-c) for subtraction.
- R4: op 5 gives T2 AND T1, op 6 gives T2 XOR T1 and op 7 gives T2 OR T1. All three produce carry and aux-carry candidates of 0.
- R5: op 9 rotates T1 left and copies bit 7 to carry. op 10 rotates right and copies bit 0 to carry. op 11 rotates left through carry and op 12 rotates right through carry. The aux-carry candidate of a rotate is 0.
- R6: flags is {S, Z, 0, AC, 0, P, 1, CY} from bit 7 to bit 0. S is result bit 7, Z is set for a zero result, and P is set when the result has an even number of ones.
- R7: fmode 0 leaves flags unchanged. fmode 1 updates S, Z, AC and P but not CY. fmode 2 updates CY only. fmode 3 updates all five flags.
- R8: With use_ac=1, ops 2 and 4 take c from a private link carry instead of CY; set_ac=1 forces that c to 1. Any op 1-4 with use_ac=1 stores its carry or borrow out in the link. The link never alters flags.
- R9: op 13 is decimal adjust of T1 and must be issued twice. The first issue records a correction from T1, AC and CY. The second issue outputs T1 plus that correction, with CY = old CY OR decimal carry.
- R10: op 8 outputs the bitwise complement of T1 and never changes flags, whatever fmode is.
- R11: op 15 sets CY and op 14 inverts CY. Each changes CY only when fmode is 2 or 3, and neither changes result.
- R12: op 16 outputs rst_idx multiplied by 8 and changes no flag.
- R13: op 0 changes neither result nor flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 8 | Operand load data |
| ld_t1 | input | 1 | Load T1 from din |
| ld_t2 | input | 1 | Load T2 from din |
| clr_t1 | input | 1 | Zero T1 (wins over ld_t1) |
| op | input | 5 | Operation code |
| fmode | input | 2 | Flag write mode |
| use_ac | input | 1 | Take carry-in from the link carry |
| set_ac | input | 1 | Force the link carry-in to 1 |
| rst_idx | input | 3 | Restart vector index |
| result | output | 8 | Registered result |
| flags | output | 8 | Status byte |

## Verification
The assertions assume that op only carries the seventeen defined codes. They also assume that set_ac is raised only together with use_ac, and that the two decimal-adjust issues see the same T1 and the same AC/CY. The stimulus loads operands only through the load tasks and drives op, fmode and the carry controls for one cycle at a time. Each issue is followed by a no-operation cycle, except for the decimal-adjust pair, which is issued back to back with the first issue in mode 0.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW = 8;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0,
    OP_ADD = 5'd1,
    OP_ADC = 5'd2,
    OP_SUB = 5'd3,
    OP_SBB = 5'd4,
    OP_AND = 5'd5,
    OP_XOR = 5'd6,
    OP_OR  = 5'd7,
    OP_CMA = 5'd8,
    OP_RLC = 5'd9,
    OP_RRC = 5'd10,
    OP_RAL = 5'd11,
    OP_RAR = 5'd12,
    OP_DAA = 5'd13,
    OP_CMC = 5'd14,
    OP_STC = 5'd15,
    OP_RST = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    FM_NONE = 2'd0,
    FM_RES  = 2'd1,
    FM_CY   = 2'd2,
    FM_ALL  = 2'd3
  } fmode_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic [7:0] status_byte(input flags_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction

endpackage

// File: rtl/alu8_operands.sv
module alu8_operands
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         ld_t1,
  input  logic         ld_t2,
  input  logic         clr_t1,
  output logic [W-1:0] t1_q,
  output logic [W-1:0] t2_q
);

  logic [W-1:0] t1_d, t2_d;
  logic         t1_en, t2_en;

  always_comb begin
    t1_en = clr_t1 | ld_t1;
    t2_en = ld_t2;
    t1_d  = clr_t1 ? '0 : din;
    t2_d  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q <= '0;
      t2_q <= '0;
    end else begin
      if (t1_en) t1_q <= t1_d;
      if (t2_en) t2_q <= t2_d;
    end
  end

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
#(
  parameter int W         = DW,
  parameter int VEC_W     = 3,
  parameter int VEC_SHIFT = 3
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     t1,
  input  logic [W-1:0]     t2,
  input  logic             cur_ac,
  input  logic             cur_cy,
  input  logic             link_q,
  input  logic             use_ac,
  input  logic             set_ac,
  input  logic [W-1:0]     fix_q,
  input  logic             fix_cy_q,
  input  logic [VEC_W-1:0] rst_idx,
  output logic [W-1:0]     res_nx,
  output logic             res_we,
  output flags_t           cand,
  output logic             szap_touch,
  output logic             cy_touch,
  output logic             link_we,
  output logic             link_nx,
  output logic             fix_we,
  output logic [W-1:0]     fix_nx,
  output logic             fix_cy_nx
);

  localparam int NIB = 4;

  logic         cin_src, cin, is_sub, carry_out, ac_add;
  logic [W-1:0] b_op;
  logic [W:0]   sum;
  logic         lo_adj, lo_c, hi_adj, dac;
  logic [NIB:0] hi_val;
  logic [W-1:0] fix_calc, dsum, vec;

  // carry source and shared adder
  always_comb begin
    cin_src = use_ac ? (set_ac | link_q) : cur_cy;
    is_sub  = (op == OP_SUB) || (op == OP_SBB);
    b_op    = is_sub ? ~t1 : t1;
    unique case (op)
      OP_ADC:  cin = cin_src;
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~cin_src;
      default: cin = 1'b0;
    endcase
    sum       = {1'b0, t2} + {1'b0, b_op} + {{W{1'b0}}, cin};
    carry_out = sum[W] ^ is_sub;
    ac_add    = t2[NIB] ^ b_op[NIB] ^ sum[NIB];
  end

  // decimal correction and restart vector
  always_comb begin
    lo_adj   = (t1[NIB-1:0] > 4'd9) || cur_ac;
    lo_c     = lo_adj && (t1[NIB-1:0] >= 4'd10);
    hi_val   = {1'b0, t1[W-1:NIB]} + {{NIB{1'b0}}, lo_c};
    hi_adj   = (hi_val > 5'd9) || cur_cy;
    fix_calc = {(hi_adj ? 4'h6 : 4'h0), (lo_adj ? 4'h6 : 4'h0)};
    dsum     = t1 + fix_q;
    dac      = t1[NIB] ^ fix_q[NIB] ^ dsum[NIB];
    vec      = '0;
    vec[VEC_SHIFT +: VEC_W] = rst_idx;
  end

  always_comb begin
    res_nx     = t1;
    res_we     = 1'b0;
    cand       = '0;
    szap_touch = 1'b0;
    cy_touch   = 1'b0;
    link_we    = 1'b0;
    link_nx    = link_q;
    fix_we     = 1'b0;
    fix_nx     = fix_q;
    fix_cy_nx  = fix_cy_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_nx     = sum[W-1:0];
        res_we     = 1'b1;
        cand.ac    = ac_add;
        cand.cy    = carry_out;
        szap_touch = 1'b1;
        cy_touch   = 1'b1;
        link_we    = use_ac;
        link_nx    = carry_out;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_nx     = (op == OP_AND) ? (t2 & t1) :
                     (op == OP_XOR) ? (t2 ^ t1) : (t2 | t1);
        res_we     = 1'b1;
        szap_touch = 1'b1;
        cy_touch   = 1'b1;
      end
      OP_CMA: begin
        res_nx = ~t1;
        res_we = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_we     = 1'b1;
        szap_touch = 1'b1;
        cy_touch   = 1'b1;
        if (op == OP_RLC)      res_nx = {t1[W-2:0], t1[W-1]};
        else if (op == OP_RRC) res_nx = {t1[0], t1[W-1:1]};
        else if (op == OP_RAL) res_nx = {t1[W-2:0], cur_cy};
        else                   res_nx = {cur_cy, t1[W-1:1]};
        cand.cy = ((op == OP_RLC) || (op == OP_RAL)) ? t1[W-1] : t1[0];
      end
      OP_DAA: begin
        res_nx     = dsum;
        res_we     = 1'b1;
        cand.ac    = dac;
        cand.cy    = cur_cy | fix_cy_q;
        szap_touch = 1'b1;
        cy_touch   = 1'b1;
        fix_we     = 1'b1;
        fix_nx     = fix_calc;
        fix_cy_nx  = hi_adj;
      end
      OP_CMC: begin
        cand.cy  = ~cur_cy;
        cy_touch = 1'b1;
      end
      OP_STC: begin
        cand.cy  = 1'b1;
        cy_touch = 1'b1;
      end
      OP_RST: begin
        res_nx = vec;
        res_we = 1'b1;
      end
      default: ;
    endcase
    cand.s = res_nx[W-1];
    cand.z = (res_nx == '0);
    cand.p = ~^res_nx;
  end

endmodule

// File: rtl/alu8_state.sv
module alu8_state
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmode_e       fmode,
  input  logic         res_we,
  input  logic [W-1:0] res_nx,
  input  flags_t       cand,
  input  logic         szap_touch,
  input  logic         cy_touch,
  input  logic         link_we,
  input  logic         link_nx,
  input  logic         fix_we,
  input  logic [W-1:0] fix_nx,
  input  logic         fix_cy_nx,
  output logic [W-1:0] result_q,
  output flags_t       flags_q,
  output logic         link_q,
  output logic [W-1:0] fix_q,
  output logic         fix_cy_q
);

  logic   szap_we, cy_we, flg_en;
  flags_t flg_d;

  always_comb begin
    szap_we = szap_touch && ((fmode == FM_RES) || (fmode == FM_ALL));
    cy_we   = cy_touch && ((fmode == FM_CY) || (fmode == FM_ALL));
    flg_en  = szap_we | cy_we;
    flg_d   = flags_q;
    if (szap_we) begin
      flg_d.s  = cand.s;
      flg_d.z  = cand.z;
      flg_d.ac = cand.ac;
      flg_d.p  = cand.p;
    end
    if (cy_we) flg_d.cy = cand.cy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      link_q   <= 1'b0;
      fix_q    <= '0;
      fix_cy_q <= 1'b0;
    end else begin
      if (res_we)  result_q <= res_nx;
      if (flg_en)  flags_q  <= flg_d;
      if (link_we) link_q   <= link_nx;
      if (fix_we) begin
        fix_q    <= fix_nx;
        fix_cy_q <= fix_cy_nx;
      end
    end
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int VEC_W       = 3,
  parameter int VEC_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    din,
  input  logic             ld_t1,
  input  logic             ld_t2,
  input  logic             clr_t1,
  input  logic [4:0]       op,
  input  logic [1:0]       fmode,
  input  logic             use_ac,
  input  logic             set_ac,
  input  logic [VEC_W-1:0] rst_idx,
  output logic [DW-1:0]    result,
  output logic [7:0]       flags
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [DW-1:0] t1_q, t2_q, res_nx, fix_q, fix_nx;
  logic          res_we, szap_touch, cy_touch, link_we, link_nx, link_q;
  logic          fix_we, fix_cy_nx, fix_cy_q;
  flags_t        cand, flags_q;

  alu8_operands #(.W(DW)) u_ops (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .din    (din),
    .ld_t1  (ld_t1),
    .ld_t2  (ld_t2),
    .clr_t1 (clr_t1),
    .t1_q   (t1_q),
    .t2_q   (t2_q)
  );

  alu8_exec #(.W(DW), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT)) u_exec (
    .op         (alu_op_e'(op)),
    .t1         (t1_q),
    .t2         (t2_q),
    .cur_ac     (flags_q.ac),
    .cur_cy     (flags_q.cy),
    .link_q     (link_q),
    .use_ac     (use_ac),
    .set_ac     (set_ac),
    .fix_q      (fix_q),
    .fix_cy_q   (fix_cy_q),
    .rst_idx    (rst_idx),
    .res_nx     (res_nx),
    .res_we     (res_we),
    .cand       (cand),
    .szap_touch (szap_touch),
    .cy_touch   (cy_touch),
    .link_we    (link_we),
    .link_nx    (link_nx),
    .fix_we     (fix_we),
    .fix_nx     (fix_nx),
    .fix_cy_nx  (fix_cy_nx)
  );

  alu8_state #(.W(DW)) u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fmode      (fmode_e'(fmode)),
    .res_we     (res_we),
    .res_nx     (res_nx),
    .cand       (cand),
    .szap_touch (szap_touch),
    .cy_touch   (cy_touch),
    .link_we    (link_we),
    .link_nx    (link_nx),
    .fix_we     (fix_we),
    .fix_nx     (fix_nx),
    .fix_cy_nx  (fix_cy_nx),
    .result_q   (result),
    .flags_q    (flags_q),
    .link_q     (link_q),
    .fix_q      (fix_q),
    .fix_cy_q   (fix_cy_q)
  );

  assign flags = status_byte(flags_q);

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    op,
  input logic [1:0]    fmode,
  input logic [2:0]    rst_idx,
  input logic          clr_t1,
  input logic [DW-1:0] t1_val,
  input logic [DW-1:0] t2_val,
  input logic [DW-1:0] result,
  input logic [7:0]    flags
);

  logic arith_or_logic;
  assign arith_or_logic = (op >= 5'd1) && (op <= 5'd7);

  a_r2_clear_t1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_t1 |=> (t1_val == '0));

  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |=> (result == $past(t2_val) + $past(t1_val)));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_or_logic && fmode[0]) |=> (flags[6] == (result == '0)));

  a_r6_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_or_logic && fmode[0]) |=> (flags[2] == ~^result));

  a_r7_mode_none: assert property (@(posedge clk) disable iff (!rst_n)
    (fmode == FM_NONE) |=> $stable(flags));

  a_r7_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fmode == FM_CY) |=> (flags[7:1] == $past(flags[7:1])));

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMA) |=> ((result == ~$past(t1_val)) && $stable(flags)));

  a_r11_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_STC) && fmode[1]) |=> flags[0]);

  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RST) |=> ((result == {2'b00, $past(rst_idx), 3'b000}) && $stable(flags)));

  a_r13_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> ($stable(result) && $stable(flags)));

endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .op      (op),
  .fmode   (fmode),
  .rst_idx (rst_idx),
  .clr_t1  (clr_t1),
  .t1_val  (t1_q),
  .t2_val  (t2_q),
  .result  (result),
  .flags   (flags)
);

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic       ld_t1, ld_t2, clr_t1;
  logic [4:0] op;
  logic [1:0] fmode;
  logic       use_ac, set_ac;
  logic [2:0] rst_idx;
  logic [7:0] result, flags;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu8_flags u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_t1(ld_t1), .ld_t2(ld_t2),
    .clr_t1(clr_t1), .op(op), .fmode(fmode), .use_ac(use_ac),
    .set_ac(set_ac), .rst_idx(rst_idx), .result(result), .flags(flags)
  );

  // {op, fmode, cy_pre, t1, t2, exp_result, exp_flags}
  localparam logic [39:0] VEC [0:11] = '{
    {5'd1,  2'd3, 1'b0, 8'hC6, 8'h3A, 8'h00, 8'h57},
    {5'd2,  2'd3, 1'b1, 8'h34, 8'h12, 8'h47, 8'h06},
    {5'd3,  2'd3, 1'b0, 8'h07, 8'h05, 8'hFE, 8'h83},
    {5'd4,  2'd3, 1'b1, 8'h0F, 8'h10, 8'h00, 8'h46},
    {5'd5,  2'd3, 1'b0, 8'h3C, 8'hF0, 8'h30, 8'h06},
    {5'd6,  2'd3, 1'b0, 8'h0F, 8'hFF, 8'hF0, 8'h86},
    {5'd7,  2'd3, 1'b0, 8'h00, 8'h00, 8'h00, 8'h46},
    {5'd9,  2'd3, 1'b0, 8'h81, 8'h00, 8'h03, 8'h07},
    {5'd10, 2'd3, 1'b0, 8'h01, 8'h00, 8'h80, 8'h83},
    {5'd11, 2'd3, 1'b0, 8'h80, 8'h00, 8'h00, 8'h47},
    {5'd12, 2'd3, 1'b1, 8'h02, 8'h00, 8'h81, 8'h86},
    {5'd1,  2'd3, 1'b0, 8'h01, 8'h7F, 8'h80, 8'h92}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load_t1(input logic [7:0] v, input logic clr);
    @(negedge clk);
    din = v; ld_t1 = 1'b1; clr_t1 = clr;
    @(negedge clk);
    ld_t1 = 1'b0; clr_t1 = 1'b0;
  endtask

  task automatic load_t2(input logic [7:0] v);
    @(negedge clk);
    din = v; ld_t2 = 1'b1;
    @(negedge clk);
    ld_t2 = 1'b0;
  endtask

  task automatic issue(input logic [4:0] o, input logic [1:0] f,
                       input logic ua, input logic sa);
    @(negedge clk);
    op = o; fmode = f; use_ac = ua; set_ac = sa;
    @(negedge clk);
    op = 5'd0; fmode = 2'd0; use_ac = 1'b0; set_ac = 1'b0;
  endtask

  task automatic daa_pair();
    @(negedge clk);
    op = 5'd13; fmode = 2'd0;
    @(negedge clk);
    op = 5'd13; fmode = 2'd3;
    @(negedge clk);
    op = 5'd0; fmode = 2'd0;
  endtask

  function automatic string req_of(input logic [4:0] o);
    if (o <= 5'd4) return "R3";
    if (o <= 5'd7) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = '0; ld_t1 = 0; ld_t2 = 0; clr_t1 = 0;
    op = '0; fmode = '0; use_ac = 0; set_ac = 0; rst_idx = '0;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 8'h00);
    chk("R1 flags in reset", flags, 8'h02);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 result after release", result, 8'h00);
    chk("R1 flags after release", flags, 8'h02);

    for (int i = 0; i < 12; i++) begin
      logic [39:0] v;
      v = VEC[i];
      issue(5'd15, 2'd2, 0, 0);
      if (!v[32]) issue(5'd14, 2'd2, 0, 0);
      load_t1(v[31:24], 1'b0);
      load_t2(v[23:16]);
      issue(v[39:35], v[34:33], 0, 0);
      chk(req_of(v[39:35]), result, v[15:8]);
      chk("R6 flags", flags, v[7:0]);
    end

    // R7 carry-only mode
    load_t1(8'h01, 0); load_t2(8'hFF);
    issue(5'd1, 2'd2, 0, 0);
    chk("R7 carry-only result", result, 8'h00);
    chk("R7 carry-only flags", flags, 8'h93);
    issue(5'd1, 2'd1, 0, 0);
    chk("R7 no-carry mode flags", flags, 8'h57);
    load_t2(8'h01);
    issue(5'd1, 2'd0, 0, 0);
    chk("R7 mode none result", result, 8'h02);
    chk("R7 mode none flags", flags, 8'h57);

    // R10 complement
    load_t1(8'h5A, 0);
    issue(5'd8, 2'd3, 0, 0);
    chk("R10 complement result", result, 8'hA5);
    chk("R10 complement flags", flags, 8'h57);

    // R11 carry set / complement, R13 result hold
    issue(5'd14, 2'd0, 0, 0);
    chk("R11 cmc mode none", flags, 8'h57);
    issue(5'd14, 2'd2, 0, 0);
    chk("R11 cmc", flags, 8'h56);
    issue(5'd15, 2'd3, 0, 0);
    chk("R11 stc", flags, 8'h57);
    chk("R11 result kept", result, 8'hA5);
    issue(5'd0, 2'd3, 0, 0);
    chk("R13 nop result", result, 8'hA5);
    chk("R13 nop flags", flags, 8'h57);

    // R12 restart vectors
    rst_idx = 3'd5;
    issue(5'd16, 2'd3, 0, 0);
    chk("R12 vector 5", result, 8'h28);
    chk("R12 flags", flags, 8'h57);
    rst_idx = 3'd7;
    issue(5'd16, 2'd0, 0, 0);
    chk("R12 vector 7", result, 8'h38);

    // R9 decimal adjust
    load_t1(8'h00, 0); load_t2(8'h00);
    issue(5'd1, 2'd3, 0, 0);
    chk("R9 setup flags", flags, 8'h46);
    load_t1(8'h9B, 0);
    daa_pair();
    chk("R9 daa both nibbles", result, 8'h01);
    chk("R9 daa flags", flags, 8'h13);
    load_t1(8'h29, 0); load_t2(8'h38);
    issue(5'd1, 2'd3, 0, 0);
    chk("R3 bcd add", result, 8'h61);
    chk("R3 bcd add flags", flags, 8'h12);
    load_t1(8'h61, 0);
    daa_pair();
    chk("R9 daa via aux carry", result, 8'h67);
    chk("R9 daa aux flags", flags, 8'h02);

    // R8 link carry increment / decrement
    load_t1(8'hFF, 0); load_t2(8'h00);
    issue(5'd2, 2'd0, 1, 1);
    chk("R8 inc low byte", result, 8'h00);
    chk("R8 flags untouched", flags, 8'h02);
    load_t1(8'h12, 0);
    issue(5'd2, 2'd0, 1, 0);
    chk("R8 inc high byte", result, 8'h13);
    load_t1(8'h00, 0);
    issue(5'd4, 2'd0, 1, 1);
    chk("R8 dec low byte", result, 8'hFF);
    load_t2(8'h20);
    issue(5'd4, 2'd0, 1, 0);
    chk("R8 dec high byte", result, 8'h1F);
    issue(5'd15, 2'd2, 0, 0);
    chk("R8 carry set", flags, 8'h03);
    load_t1(8'h01, 0); load_t2(8'h00);
    issue(5'd2, 2'd0, 1, 1);
    chk("R8 inc no link", result, 8'h02);
    load_t1(8'h05, 0);
    issue(5'd2, 2'd0, 1, 0);
    chk("R8 CY ignored", result, 8'h05);

    // R2 clear T1
    load_t1(8'h55, 0); load_t2(8'h10);
    @(negedge clk); clr_t1 = 1'b1;
    @(negedge clk); clr_t1 = 1'b0;
    issue(5'd1, 2'd0, 0, 0);
    chk("R2 clear T1", result, 8'h10);
    load_t1(8'h77, 1);
    issue(5'd1, 2'd0, 0, 0);
    chk("R2 clear beats load", result, 8'h10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule